// File: doc/BRIEF.md
# Escalating Watchdog Timer

A register-mapped watchdog that counts down a power-of-two period and demands periodic service from software. Service means writing a fixed key word to the restart register, or reading the interrupt-acknowledge register. If the count reaches zero without service, the block responds in one of two ways. In direct mode it fires a system reset pulse at once. In escalating mode it first raises a level interrupt. It fires the reset pulse only if a second period also runs out while that interrupt is still pending.

Software programs a 4-bit period exponent and picks the response mode. It then sets the enable bit, which cannot be cleared again short of a hardware reset. The period exponent is sampled only when the counter is restarted, so a reprogrammed value never shortens a period already in progress. Registers are reached through a single-cycle strobe bus: one write strobe, one read strobe, a byte address and a 32-bit data word.

Top module: `guard_timer`

## Requirements
- R1: After reset, the interrupt and reset outputs are low, the control and period registers read 0, the status register reads 0, and the count register reads 2^BASE_SHIFT-1.
- R2: Control bit 0 (offset 0x00) is the enable. Once it has been written 1, a later write of 0 leaves it reading 1 until a hardware reset.
- R3: After a restart with period exponent e (bits [3:0] at offset 0x04), the count register (offset 0x08) reads 2^(BASE_SHIFT+e)-1 and falls by one per clock. Expiry is registered exactly 2^(BASE_SHIFT+e) clocks after the restart edge.
- R4: Writing exactly 0x76 to the restart register (offset 0x0C) reloads the counter. A write of any other value there leaves the count running undisturbed.
- R5: A new period exponent takes effect only at the next restart. The period in progress, and the automatic reload after it, keep the old exponent.
- R6: With control bit 1 set, the first expiry sets the pending interrupt. The irq output then goes high and status bit 0 (offset 0x10) reads 1. A second expiry while it is still pending fires the reset pulse, and the interrupt stays pending.
- R7: With control bit 1 clear, an expiry fires the reset pulse and leaves the interrupt low.
- R8: A read of the acknowledge register (offset 0x14) clears the pending interrupt and restarts the counter. A later expiry is then treated as a first expiry again.
- R9: The reset pulse stays high for exactly RST_CYCLES clocks, starting on the clock edge that registers the expiry.
- R10: A restart that lands in the same cycle as the counter reaching zero wins. No expiry is registered, and the counter reloads.
- R11: Writes to the count, status and acknowledge registers have no effect on the count or on the pending interrupt.
- R12: After an expiry the counter reloads by itself and keeps running.
- R13: While the enable is clear, the counter holds its value and never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid during bus_rd |
| irq | output | 1 | Level interrupt, high while an expiry is pending |
| sys_rst | output | 1 | System reset pulse |

## Verification
Two functions can fall in the same clock: a restart, either a key write or an acknowledge read, and the counter reaching zero. The bench counts edges from a known restart so that a second key write lands on the very edge at which the count is zero. It then judges the outcome at the ports: the interrupt stays low, the count reads the full reload value, and the next expiry comes a full period later. A bus write to the status or acknowledge register while an interrupt is pending is the other overlap. The check is that the interrupt survives it.

// File: rtl/guard_timer_pkg.sv
// Shared constants for the escalating watchdog: register offsets, the
// restart key and the width of the period exponent field.
package guard_timer_pkg;

    localparam int unsigned EXP_W = 4;

    localparam logic [7:0] OFS_CTRL    = 8'h00;
    localparam logic [7:0] OFS_PERIOD  = 8'h04;
    localparam logic [7:0] OFS_COUNT   = 8'h08;
    localparam logic [7:0] OFS_RESTART = 8'h0C;
    localparam logic [7:0] OFS_STATUS  = 8'h10;
    localparam logic [7:0] OFS_ACK     = 8'h14;

    localparam logic [31:0] RESTART_KEY = 32'h0000_0076;

    typedef struct packed {
        logic escalate;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/gt_regfile.sv
// Register file of the watchdog. It decodes single-cycle read and write
// strobes, keeps the sticky enable, the mode bit and the programmed period
// exponent, and turns key writes and acknowledge reads into a restart pulse.
// Assumes: byte addresses, word-aligned registers, read data combinational.
module gt_regfile
    import guard_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              pending_i,
    output logic              enable_o,
    output logic              escalate_o,
    output logic [EXP_W-1:0]  period_exp_o,
    output logic              restart_o,
    output logic              ack_o
);

    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_PERIOD  = ADDR_W'(OFS_PERIOD);
    localparam logic [ADDR_W-1:0] A_COUNT   = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFS_RESTART);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_ACK     = ADDR_W'(OFS_ACK);
    localparam logic [DATA_W-1:0] KEY       = DATA_W'(RESTART_KEY);

    ctrl_t            ctrl_q;
    logic [EXP_W-1:0] exp_q;
    logic             wr_ctrl, wr_period, key_hit, ack_rd;

    // Address decode of the strobes that have side effects
    always_comb begin
        wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
        wr_period = bus_wr && (bus_addr == A_PERIOD);
        key_hit   = bus_wr && (bus_addr == A_RESTART) && (bus_wdata == KEY);
        ack_rd    = bus_rd && (bus_addr == A_ACK);
    end

    // Control register: enable only ever sets, mode bit freely writable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.enable   <= ctrl_q.enable | bus_wdata[0];
            ctrl_q.escalate <= bus_wdata[1];
        end
    end

    // Programmed period exponent, consumed by the counter at restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
        end else if (wr_period) begin
            exp_q <= bus_wdata[EXP_W-1:0];
        end
    end

    // Read data multiplexer, zero outside a read or on unmapped offsets
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == A_CTRL)
                bus_rdata = DATA_W'({ctrl_q.escalate, ctrl_q.enable});
            else if (bus_addr == A_PERIOD)
                bus_rdata = DATA_W'(exp_q);
            else if (bus_addr == A_COUNT)
                bus_rdata = DATA_W'(count_i);
            else if (bus_addr == A_STATUS)
                bus_rdata = DATA_W'(pending_i);
        end
    end

    assign enable_o     = ctrl_q.enable;
    assign escalate_o   = ctrl_q.escalate;
    assign period_exp_o = exp_q;
    assign restart_o    = key_hit || ack_rd;
    assign ack_o        = ack_rd;

    AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        enable_o |=> enable_o);  // R2

endmodule

// File: rtl/gt_countdown.sv
// Period down-counter. A restart latches the programmed exponent and loads
// 2^(BASE_SHIFT+e)-1; reaching zero while enabled produces a one-cycle
// expiry and an automatic reload with the latched exponent.
// Assumes: BASE_SHIFT + 2^EXP_W - 1 < CNT_W so every period fits.
module gt_countdown
    import guard_timer_pkg::*;
#(
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned BASE_SHIFT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             restart_i,
    input  logic [EXP_W-1:0] period_exp_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t ONE = CNT_W'(1);

    cnt_t             cnt_q;
    logic [EXP_W-1:0] live_exp_q;
    cnt_t             load_new, load_live;

    // Reload values for a fresh restart and for an automatic wrap
    always_comb begin
        load_new  = (ONE << (BASE_SHIFT + int'(period_exp_i))) - ONE;
        load_live = (ONE << (BASE_SHIFT + int'(live_exp_q))) - ONE;
    end

    // Expiry: zero reached while running and not overridden by a restart
    assign expire_o = enable_i && (cnt_q == '0) && !restart_i;

    // Exponent in force for the current period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_exp_q <= '0;
        end else if (restart_i) begin
            live_exp_q <= period_exp_i;
        end
    end

    // Count register: restart, wrap, decrement or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= (ONE << BASE_SHIFT) - ONE;
        end else if (restart_i) begin
            cnt_q <= load_new;
        end else if (expire_o) begin
            cnt_q <= load_live;
        end else if (enable_i) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign count_o = cnt_q;

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i && !restart_i && (count_o != '0) |=> count_o == $past(count_o) - ONE);  // R3
    AST_KEY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> count_o == (ONE << (BASE_SHIFT + int'($past(period_exp_i)))) - ONE);  // R4
    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |-> !expire_o);  // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i && !restart_i |=> $stable(count_o));  // R13

endmodule

// File: rtl/gt_response.sv
// Two-stage response logic. Tracks the pending interrupt, escalates a
// second expiry (or any expiry in direct mode) into a reset pulse of fixed
// length, and clears the pending flag on acknowledge.
// Assumes: acknowledge and expiry never coincide (acknowledge restarts).
module gt_response #(
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic escalate_i,
    input  logic ack_i,
    output logic irq_o,
    output logic sys_rst_o
);

    localparam int unsigned PW = $clog2(RST_CYCLES + 1);
    localparam logic [PW-1:0] PULSE_LEN = PW'(RST_CYCLES);

    logic          pend_q;
    logic [PW-1:0] pulse_q;
    logic          fire;

    // A reset is due on direct-mode expiry or expiry with interrupt pending
    assign fire = expire_i && (!escalate_i || pend_q);

    // Pending interrupt: set on first-stage expiry, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (ack_i) begin
            pend_q <= 1'b0;
        end else if (expire_i && escalate_i) begin
            pend_q <= 1'b1;
        end
    end

    // Reset pulse length counter, retriggered by every fire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else if (fire) begin
            pulse_q <= PULSE_LEN;
        end else if (pulse_q != '0) begin
            pulse_q <= pulse_q - 1'b1;
        end
    end

    assign irq_o     = pend_q;
    assign sys_rst_o = (pulse_q != '0);

    AST_FIRST_STAGE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i && escalate_i |=> irq_o);  // R6
    AST_ESCALATE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i && escalate_i && irq_o |=> sys_rst_o);  // R6
    AST_DIRECT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i && !escalate_i |=> sys_rst_o);  // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !irq_o);  // R8
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(expire_i));  // R9

endmodule

// File: rtl/guard_timer.sv
// Top of the escalating watchdog: register file, period counter and
// response logic. Assumes a single clock domain and single-cycle bus
// strobes; read data is valid in the same cycle as bus_rd.
module guard_timer #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned BASE_SHIFT = 16,
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sys_rst
);

    import guard_timer_pkg::*;

    logic             enable, escalate, restart, ack, expire;
    logic [EXP_W-1:0] period_exp;
    logic [CNT_W-1:0] count;

    gt_regfile #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .count_i     (count),
        .pending_i   (irq),
        .enable_o    (enable),
        .escalate_o  (escalate),
        .period_exp_o(period_exp),
        .restart_o   (restart),
        .ack_o       (ack)
    );

    gt_countdown #(
        .CNT_W     (CNT_W),
        .BASE_SHIFT(BASE_SHIFT)
    ) count_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable),
        .restart_i   (restart),
        .period_exp_i(period_exp),
        .count_o     (count),
        .expire_o    (expire)
    );

    gt_response #(
        .RST_CYCLES(RST_CYCLES)
    ) resp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire_i  (expire),
        .escalate_i(escalate),
        .ack_i     (ack),
        .irq_o     (irq),
        .sys_rst_o (sys_rst)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !expire);  // R13

endmodule

// File: tb/guard_timer_tb_top.sv
// Self-checking bench with a short base period (BASE_SHIFT=2) so that
// period exponents 0..4 and both response modes can be swept in full.
module guard_timer_tb_top;

    localparam int unsigned BASE = 2;
    localparam int unsigned PULSE = 8;
    localparam logic [7:0] A_CTRL = 8'h00, A_PER = 8'h04, A_CNT = 8'h08,
                           A_RST = 8'h0C, A_STA = 8'h10, A_ACK = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sys_rst;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    guard_timer #(
        .ADDR_W(8), .DATA_W(32), .CNT_W(32), .BASE_SHIFT(BASE), .RST_CYCLES(PULSE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sys_rst(sys_rst)
    );

    function automatic int period(input int e);
        return 1 << (BASE + e);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_n(2);
        rst_n = 1'b1;
    endtask

    // Reset, program exponent and mode, enable, then kick; returns one
    // negedge after the kick edge.
    task automatic arm(input int e, input bit esc);
        do_reset();
        bus_write(A_PER, 32'(e));
        bus_write(A_CTRL, {30'd0, esc, 1'b1});
        bus_write(A_RST, 32'h76);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int hi;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 sys_rst", 32'(sys_rst), 0);
        bus_read(A_CTRL, rd);  check("R1 ctrl", rd, 0);
        bus_read(A_PER, rd);   check("R1 period", rd, 0);
        bus_read(A_STA, rd);   check("R1 status", rd, 0);
        bus_read(A_CNT, rd);   check("R1 count", rd, 32'(period(0) - 1));

        // R13 disabled counter holds and never expires
        wait_n(20);
        bus_read(A_CNT, rd);   check("R13 count held", rd, 32'(period(0) - 1));
        check("R13 no irq", 32'(irq), 0);
        check("R13 no reset", 32'(sys_rst), 0);

        // R2 enable is sticky
        bus_write(A_CTRL, 32'h1);
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CTRL, rd);  check("R2 enable sticky", rd & 32'h1, 1);

        // R3 R6 R7 sweep over exponents and both modes
        for (int e = 0; e < 5; e++) begin
            for (int m = 0; m < 2; m++) begin
                arm(e, m[0]);
                bus_read(A_CNT, rd);
                check("R3 reload value", rd, 32'(period(e) - 1));
                wait_n(period(e) - 2);
                check("R3 no early irq", 32'(irq), 0);
                check("R3 no early reset", 32'(sys_rst), 0);
                wait_n(1);
                if (m == 1) begin
                    check("R6 first expiry irq", 32'(irq), 1);
                    check("R6 first expiry no reset", 32'(sys_rst), 0);
                end else begin
                    check("R7 direct reset", 32'(sys_rst), 1);
                    check("R7 no irq", 32'(irq), 0);
                end
            end
        end

        // R6 R12 escalation on second expiry, auto reload in between
        arm(1, 1'b1);
        wait_n(period(1));
        check("R6 irq", 32'(irq), 1);
        bus_read(A_CNT, rd);   check("R12 auto reload", rd, 32'(period(1) - 1));
        bus_read(A_STA, rd);   check("R6 status bit", rd, 1);
        wait_n(period(1) - 3);
        check("R6 no reset yet", 32'(sys_rst), 0);
        wait_n(1);
        check("R6 second expiry reset", 32'(sys_rst), 1);
        check("R6 irq stays", 32'(irq), 1);

        // R9 reset pulse length in direct mode
        arm(2, 1'b0);
        wait_n(period(2) - 1);
        check("R9 low before", 32'(sys_rst), 0);
        hi = 0;
        for (int i = 0; i < PULSE + 3; i++) begin
            wait_n(1);
            if (sys_rst) hi++;
        end
        check("R9 pulse length", 32'(hi), 32'(PULSE));

        // R8 acknowledge clears and restarts
        arm(1, 1'b1);
        wait_n(period(1));
        check("R8 irq set", 32'(irq), 1);
        bus_read(A_ACK, rd);
        check("R8 irq cleared", 32'(irq), 0);
        bus_read(A_CNT, rd);   check("R8 restarted", rd, 32'(period(1) - 1));
        wait_n(period(1) - 2);
        check("R8 quiet", 32'(irq), 0);
        wait_n(1);
        check("R8 first stage again irq", 32'(irq), 1);
        check("R8 first stage again no reset", 32'(sys_rst), 0);

        // R4 wrong key ignored, R11 count register write ignored
        arm(2, 1'b1);
        bus_write(A_RST, 32'h75);
        bus_read(A_CNT, rd);   check("R4 wrong key", rd, 32'(period(2) - 2));
        bus_write(A_CNT, 32'h0);
        bus_read(A_CNT, rd);   check("R11 count write ignored", rd, 32'(period(2) - 4));
        bus_write(A_RST, 32'h76);
        bus_read(A_CNT, rd);   check("R4 key reload", rd, 32'(period(2) - 1));

        // R11 status and acknowledge writes leave irq pending
        arm(0, 1'b1);
        wait_n(period(0));
        bus_write(A_ACK, 32'hFFFF_FFFF);
        bus_write(A_STA, 32'h0);
        check("R11 irq survives writes", 32'(irq), 1);

        // R5 new exponent waits for next restart
        arm(1, 1'b1);
        bus_write(A_PER, 32'h3);
        wait_n(period(1) - 2);
        check("R5 old period irq low", 32'(irq), 0);
        wait_n(1);
        check("R5 old period irq", 32'(irq), 1);
        bus_write(A_RST, 32'h76);
        bus_read(A_CNT, rd);   check("R5 new period", rd, 32'(period(3) - 1));

        // R10 restart in the zero cycle wins
        arm(2, 1'b1);
        wait_n(period(2) - 1);
        bus_write(A_RST, 32'h76);
        check("R10 no expiry", 32'(irq), 0);
        bus_read(A_CNT, rd);   check("R10 reloaded", rd, 32'(period(2) - 1));
        wait_n(period(2) - 2);
        check("R10 still quiet", 32'(irq), 0);
        wait_n(1);
        check("R10 next expiry", 32'(irq), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule